// File: doc/BRIEF.md
# Tuning-Store Programming Sequencer

This block runs on the host side of a digitally tuned capacitor. It stores an 11-bit capacitance control word into the part's one-time-style bit store. It drives three digital lines toward the part: a serial clock, a serial data line and a program strobe. It reads back one stored bit at a time on a single sense input. A stored bit selects its capacitor when it is low, so the sequencer programs the bitwise inverse of the requested word.

A request carries a desired word and an erase flag. If erase is set, the sequencer first shifts in an all-ones frame and fires one strobe, which returns every stored bit to 1. It then reads all bits. It counts how many differ from the inverted target. It fires one strobe for each bit that must go from 1 to 0, and reads every bit again to verify. If the request would need a bit to go from 0 back to 1 without an erase, the request is refused and no strobe fires.

The request side is a valid/ready handshake. `req_ready` is high only while the sequencer is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high. While the sequencer is busy, `req_ready` stays low, and a held `req_valid` waits without effect. The serial clock half-period, the strobe length and the post-frame gap are all parameters counted in system clocks.

Top module: `trim_prog_seq`

## Requirements
- R1: `req_ready` is 1 exactly when the sequencer is idle. `req_word` and `req_erase` are taken only in a cycle with `req_valid` and `req_ready` both high, and `req_ready` is 0 in the next cycle. A `req_valid` held while busy starts nothing.
- R2: Every frame shifts 11 bits, with bit 0 first and bit 10 last. The part captures each bit on a rising edge of `ser_clk`. Each low and high phase of `ser_clk` inside a frame lasts HALF_DIV system clocks. `ser_data` never changes in the cycle in which `ser_clk` rises.
- R3: The programmed target is the bitwise inverse of `req_word`: a stored 0 means the capacitor is selected.
- R4: To read stored bit k, the sequencer shifts a frame whose only 0 is at bit k. It then holds `ser_clk` and `ser_data` both at 1 for HALF_DIV clocks and samples `rd_bit` in the last of those clocks.
- R5: When `req_erase` is 1, an all-ones frame followed by one strobe comes before the first read pass.
- R6: `diff_count` equals the number of bit positions where the first read pass differs from the target.
- R7: One program cycle is issued for each bit that is read as 1 and has a target of 0, in ascending bit order. Each uses a frame whose only 0 is that bit. The strobe is high for exactly PULSE_LEN clocks, with `ser_clk` and `ser_data` low during it. Bits that already match get no cycle.
- R8: If any bit reads 0 where the target is 1, `error` is set. No strobe is issued and no verify pass is run.
- R9: After the writes, all 11 bits are read again, and `error` is set if any of them differs from the target.
- R10: `done` is a single-cycle pulse at the end of each request. `error` and `diff_count` are valid from `done` and hold while idle until the next request is accepted.
- R11: After reset: `req_ready` 1, `ser_clk`, `ser_data`, `prog_strobe`, `done` and `error` all 0, and `diff_count` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_word | input | 11 | Desired control word (1 = capacitor on) |
| req_erase | input | 1 | Erase the store before programming |
| ser_clk | output | 1 | Serial clock to the part |
| ser_data | output | 1 | Serial data / bit select to the part |
| prog_strobe | output | 1 | Program strobe (digital stand-in for the program pulse) |
| rd_bit | input | 1 | Sensed level of the selected stored bit |
| done | output | 1 | End-of-request pulse |
| error | output | 1 | Refused request or verify mismatch |
| diff_count | output | 4 | Differing bits found by the first read pass |

## Verification
The hardest case to reach from the ports is a verify mismatch. A well-behaved store always ends up holding what was written, so the verify check would never fire. The bench's store model therefore has a stuck-bit mask that silently ignores program cycles on chosen positions. A request that needs one of those bits runs its write pass normally and must then report an error from the verify pass. The refusal path is reached without any fault injection: the bench issues a request, without erase, that clears a bit programmed by an earlier request.

// File: rtl/trim_prog_pkg.sv
package trim_prog_pkg;

  typedef enum logic [2:0] {
    TX_IDLE,
    TX_LO,
    TX_HI,
    TX_POST,
    TX_GAP
  } tx_state_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ERASE,
    SQ_READ,
    SQ_EVAL,
    SQ_WRITE,
    SQ_CHECK,
    SQ_FINISH
  } sq_state_e;

  function automatic int unsigned count_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += 32'(v[i]);
    return n;
  endfunction

endpackage

// File: rtl/trim_prog_tx.sv
module trim_prog_tx
  import trim_prog_pkg::*;
#(
  parameter int W         = 11,
  parameter int HALF_DIV  = 1250,
  parameter int PULSE_LEN = 2500000,
  parameter int GAP_LEN   = 1250
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         is_prog,
  input  logic [W-1:0] frame,
  output logic         ser_clk,
  output logic         ser_data,
  output logic         prog_strobe,
  output logic         sample_en,
  output logic         fin
);

  localparam int M1    = (HALF_DIV > PULSE_LEN) ? HALF_DIV : PULSE_LEN;
  localparam int M2    = (M1 > GAP_LEN) ? M1 : GAP_LEN;
  localparam int CNT_W = $clog2(M2 + 1);
  localparam int IDX_W = $clog2(W);

  tx_state_e          st;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   lim;
  logic [IDX_W-1:0]   bidx;
  logic [W-1:0]       sh;
  logic               prog_q;
  logic               last;

  always_comb begin
    case (st)
      TX_POST: lim = prog_q ? CNT_W'(PULSE_LEN - 1) : CNT_W'(HALF_DIV - 1);
      TX_GAP:  lim = CNT_W'(GAP_LEN - 1);
      default: lim = CNT_W'(HALF_DIV - 1);
    endcase
  end

  assign last = (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= TX_IDLE;
      cnt    <= '0;
      bidx   <= '0;
      sh     <= '0;
      prog_q <= 1'b0;
    end else begin
      case (st)
        TX_IDLE: begin
          cnt <= '0;
          if (go) begin
            sh     <= frame;
            prog_q <= is_prog;
            bidx   <= '0;
            st     <= TX_LO;
          end
        end
        TX_LO: begin
          if (last) begin
            cnt <= '0;
            st  <= TX_HI;
          end else cnt <= cnt + 1'b1;
        end
        TX_HI: begin
          if (last) begin
            cnt <= '0;
            if (bidx == IDX_W'(W - 1)) st <= TX_POST;
            else begin
              sh   <= sh >> 1;
              bidx <= bidx + 1'b1;
              st   <= TX_LO;
            end
          end else cnt <= cnt + 1'b1;
        end
        TX_POST: begin
          if (last) begin
            cnt <= '0;
            st  <= TX_GAP;
          end else cnt <= cnt + 1'b1;
        end
        TX_GAP: begin
          if (last) begin
            cnt <= '0;
            st  <= TX_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign ser_clk     = (st == TX_HI) || (st == TX_POST && !prog_q);
  assign ser_data    = (st == TX_LO || st == TX_HI) ? sh[0] : (st == TX_POST && !prog_q);
  assign prog_strobe = (st == TX_POST) && prog_q;
  assign sample_en   = (st == TX_POST) && !prog_q && last;
  assign fin         = (st == TX_GAP) && last;

endmodule

// File: rtl/trim_prog_cmp.sv
module trim_prog_cmp
  import trim_prog_pkg::*;
#(
  parameter int W  = 11,
  parameter int CW = 4
) (
  input  logic [W-1:0]  cur,
  input  logic [W-1:0]  target,
  output logic [W-1:0]  need_mask,
  output logic          bad,
  output logic [CW-1:0] diff_cnt
);

  logic [W-1:0] up_mask;

  for (genvar g = 0; g < W; g++) begin : g_bit
    assign need_mask[g] = cur[g] & ~target[g];
    assign up_mask[g]   = ~cur[g] & target[g];
  end

  assign bad      = |up_mask;
  assign diff_cnt = CW'(count_ones(32'(cur ^ target)));

endmodule

// File: rtl/trim_prog_ctrl.sv
module trim_prog_ctrl
  import trim_prog_pkg::*;
#(
  parameter int W  = 11,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [W-1:0]  req_word,
  input  logic          req_erase,
  output logic          req_ready,
  input  logic          rd_bit,
  input  logic          sample_en,
  input  logic          fin,
  input  logic [W-1:0]  need_mask,
  input  logic          bad,
  input  logic [CW-1:0] diff_cnt,
  output logic          go,
  output logic          is_prog,
  output logic [W-1:0]  frame,
  output logic [W-1:0]  cur,
  output logic [W-1:0]  target,
  output logic          done,
  output logic          error,
  output logic [CW-1:0] diff_count
);

  localparam int IDX_W = $clog2(W);

  sq_state_e        st;
  logic [IDX_W-1:0] idx;
  logic             busy;
  logic             verify;
  logic             last_idx;
  logic [W-1:0]     sel_frame;

  assign last_idx  = (idx == IDX_W'(W - 1));
  assign sel_frame = ~(W'(1) << idx);
  assign req_ready = (st == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SQ_IDLE;
      idx        <= '0;
      busy       <= 1'b0;
      verify     <= 1'b0;
      go         <= 1'b0;
      is_prog    <= 1'b0;
      frame      <= '1;
      cur        <= '0;
      target     <= '0;
      done       <= 1'b0;
      error      <= 1'b0;
      diff_count <= '0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (req_valid) begin
            target     <= ~req_word;
            idx        <= '0;
            verify     <= 1'b0;
            error      <= 1'b0;
            diff_count <= '0;
            if (req_erase) begin
              frame   <= '1;
              is_prog <= 1'b1;
              go      <= 1'b1;
              busy    <= 1'b1;
              st      <= SQ_ERASE;
            end else begin
              busy <= 1'b0;
              st   <= SQ_READ;
            end
          end
        end
        SQ_ERASE: begin
          if (fin) begin
            busy <= 1'b0;
            st   <= SQ_READ;
          end
        end
        SQ_READ: begin
          if (!busy) begin
            frame   <= sel_frame;
            is_prog <= 1'b0;
            go      <= 1'b1;
            busy    <= 1'b1;
          end
          if (sample_en) cur[idx] <= rd_bit;
          if (fin) begin
            busy <= 1'b0;
            if (last_idx) begin
              idx <= '0;
              st  <= verify ? SQ_CHECK : SQ_EVAL;
            end else idx <= idx + 1'b1;
          end
        end
        SQ_EVAL: begin
          diff_count <= diff_cnt;
          if (bad) begin
            error <= 1'b1;
            st    <= SQ_FINISH;
          end else st <= SQ_WRITE;
        end
        SQ_WRITE: begin
          if (!busy) begin
            if (need_mask[idx]) begin
              frame   <= sel_frame;
              is_prog <= 1'b1;
              go      <= 1'b1;
              busy    <= 1'b1;
            end else if (last_idx) begin
              idx    <= '0;
              verify <= 1'b1;
              st     <= SQ_READ;
            end else idx <= idx + 1'b1;
          end else if (fin) begin
            busy <= 1'b0;
            if (last_idx) begin
              idx    <= '0;
              verify <= 1'b1;
              st     <= SQ_READ;
            end else idx <= idx + 1'b1;
          end
        end
        SQ_CHECK: begin
          error <= (cur != target);
          st    <= SQ_FINISH;
        end
        SQ_FINISH: begin
          done   <= 1'b1;
          verify <= 1'b0;
          st     <= SQ_IDLE;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/trim_prog_seq.sv
module trim_prog_seq
  import trim_prog_pkg::*;
#(
  parameter int WORD_W    = 11,
  parameter int HALF_DIV  = 1250,
  parameter int PULSE_LEN = 2500000,
  parameter int GAP_LEN   = 1250,
  localparam int CW       = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [WORD_W-1:0] req_word,
  input  logic              req_erase,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              prog_strobe,
  input  logic              rd_bit,
  output logic              done,
  output logic              error,
  output logic [CW-1:0]     diff_count
);

  logic              go;
  logic              is_prog;
  logic [WORD_W-1:0] frame;
  logic [WORD_W-1:0] cur;
  logic [WORD_W-1:0] target;
  logic [WORD_W-1:0] need_mask;
  logic              bad;
  logic [CW-1:0]     diff_cnt;
  logic              sample_en;
  logic              fin;

  trim_prog_ctrl #(.W(WORD_W), .CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_word   (req_word),
    .req_erase  (req_erase),
    .req_ready  (req_ready),
    .rd_bit     (rd_bit),
    .sample_en  (sample_en),
    .fin        (fin),
    .need_mask  (need_mask),
    .bad        (bad),
    .diff_cnt   (diff_cnt),
    .go         (go),
    .is_prog    (is_prog),
    .frame      (frame),
    .cur        (cur),
    .target     (target),
    .done       (done),
    .error      (error),
    .diff_count (diff_count)
  );

  trim_prog_cmp #(.W(WORD_W), .CW(CW)) u_cmp (
    .cur       (cur),
    .target    (target),
    .need_mask (need_mask),
    .bad       (bad),
    .diff_cnt  (diff_cnt)
  );

  trim_prog_tx #(
    .W         (WORD_W),
    .HALF_DIV  (HALF_DIV),
    .PULSE_LEN (PULSE_LEN),
    .GAP_LEN   (GAP_LEN)
  ) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .is_prog     (is_prog),
    .frame       (frame),
    .ser_clk     (ser_clk),
    .ser_data    (ser_data),
    .prog_strobe (prog_strobe),
    .sample_en   (sample_en),
    .fin         (fin)
  );

endmodule

// File: rtl/trim_prog_chk.sv
module trim_prog_chk #(
  parameter int PULSE_LEN = 2500000,
  parameter int CW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          ser_clk,
  input logic          ser_data,
  input logic          prog_strobe,
  input logic          done,
  input logic          error,
  input logic [CW-1:0] diff_count
);

  logic [31:0] strobe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_run <= '0;
    else if (prog_strobe) strobe_run <= strobe_run + 1'b1;
    else strobe_run <= '0;
  end

  p_ready_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_data_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data));

  p_strobe_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_strobe |-> (!ser_clk && !ser_data));

  p_strobe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_strobe) |-> (strobe_run == 32'(PULSE_LEN)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> ($stable(error) && $stable(diff_count)));

endmodule

bind trim_prog_seq trim_prog_chk #(.PULSE_LEN(PULSE_LEN), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .ser_clk     (ser_clk),
  .ser_data    (ser_data),
  .prog_strobe (prog_strobe),
  .done        (done),
  .error       (error),
  .diff_count  (diff_count)
);

// File: tb/trim_prog_seq_bench.sv
module trim_prog_seq_bench;

  localparam int HALF  = 2;
  localparam int PULSE = 8;
  localparam int GAP   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [10:0] req_word = '0;
  logic        req_erase = 1'b0;
  logic        ser_clk, ser_data, prog_strobe, rd_bit, done, error;
  logic [3:0]  diff_count;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  trim_prog_seq #(
    .WORD_W(11), .HALF_DIV(HALF), .PULSE_LEN(PULSE), .GAP_LEN(GAP)
  ) u_trim_prog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_word(req_word), .req_erase(req_erase), .ser_clk(ser_clk),
    .ser_data(ser_data), .prog_strobe(prog_strobe), .rd_bit(rd_bit),
    .done(done), .error(error), .diff_count(diff_count)
  );

  // Store model: shift capture, erase/program on strobe, sense on clk&data high.
  logic [10:0] cap = '1;
  logic [10:0] store = '1;
  logic [10:0] stuck = '0;
  logic        sclk_q = 1'b0, strb_q = 1'b0;
  int          n_erase = 0, n_prog = 0, n_acc = 0, last_idx = -1;
  logic [10:0] wmask = '0;
  bit          order_ok = 1'b1, frame_ok = 1'b1;
  int          ph_len = 0, min_hi = 1000000, min_lo = 1000000;
  int          str_len = 0, last_str = 0;

  always_comb begin
    rd_bit = 1'b0;
    if (ser_clk && ser_data)
      for (int j = 0; j < 11; j++) if (!cap[j]) rd_bit = store[j];
  end

  always @(posedge clk) begin
    if (req_valid && req_ready) begin
      n_acc++; n_erase = 0; n_prog = 0; wmask = '0; last_idx = -1;
    end
    if (ser_clk && !sclk_q) cap <= {ser_data, cap[10:1]};
    if (prog_strobe && !strb_q) begin
      if (&cap) begin
        store <= '1; n_erase++;
      end else begin
        int zeros, zi;
        zeros = 0; zi = 0;
        for (int j = 0; j < 11; j++) if (!cap[j]) begin zeros++; zi = j; end
        if (zeros != 1) frame_ok = 1'b0;
        if (zi <= last_idx) order_ok = 1'b0;
        last_idx = zi;
        wmask[zi] = 1'b1;
        if (!stuck[zi]) store[zi] <= 1'b0;
        n_prog++;
      end
    end
    if (prog_strobe) str_len++;
    else if (strb_q) begin last_str = str_len; str_len = 0; end
    if (ser_clk == sclk_q) ph_len++;
    else begin
      if (sclk_q) begin if (ph_len < min_hi) min_hi = ph_len; end
      else if (n_acc > 0) begin if (ph_len < min_lo) min_lo = ph_len; end
      ph_len = 1;
    end
    sclk_q = ser_clk;
    strb_q = prog_strobe;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [10:0] w, input logic e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_word = w; req_erase = e; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk("R10", "done seen", 32'(done), 32'd1);
    @(negedge clk);
    chk("R10", "done one cycle", 32'(done), 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11", "ready", 32'(req_ready), 1);
    chk("R11", "outs", {ser_clk, ser_data, prog_strobe, done, error}, 0);
    chk("R11", "diff", 32'(diff_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_example();
    send(11'b00000010100, 1'b1);
    chk("R1", "busy after accept", 32'(req_ready), 0);
    wait_done();
    chk("R5", "erase strobes", n_erase, 1);
    chk("R6", "diff count", 32'(diff_count), 2);
    chk("R7", "written bits", 32'(wmask), 32'h014);
    chk("R7", "strobe width", last_str, PULSE);
    chk("R3", "store", 32'(store), 32'h7EB);
    chk("R9", "no error", 32'(error), 0);
  endtask

  task automatic t_incr();
    send(11'h414, 1'b0);
    wait_done();
    chk("R5", "no erase", n_erase, 0);
    chk("R6", "diff count", 32'(diff_count), 1);
    chk("R7", "written bits", 32'(wmask), 32'h400);
    chk("R3", "store", 32'(store), 32'h3EB);
  endtask

  task automatic t_same();
    send(11'h414, 1'b0);
    wait_done();
    chk("R4", "diff count zero", 32'(diff_count), 0);
    chk("R7", "no program", n_prog, 0);
    chk("R9", "no error", 32'(error), 0);
    repeat (5) @(negedge clk);
    chk("R10", "error held", 32'(error), 0);
  endtask

  task automatic t_refuse();
    send(11'h404, 1'b0);
    wait_done();
    chk("R8", "error", 32'(error), 1);
    chk("R8", "no strobe", n_prog + n_erase, 0);
    chk("R6", "diff count", 32'(diff_count), 1);
    chk("R8", "store kept", 32'(store), 32'h3EB);
    repeat (5) @(negedge clk);
    chk("R10", "error held", 32'(error), 1);
  endtask

  task automatic t_full();
    send(11'h7FF, 1'b1);
    wait_done();
    chk("R6", "diff count", 32'(diff_count), 11);
    chk("R7", "prog count", n_prog, 11);
    chk("R7", "ascending", 32'(order_ok), 1);
    chk("R4", "single-zero frames", 32'(frame_ok), 1);
    chk("R3", "store", 32'(store), 0);
    chk("R9", "no error", 32'(error), 0);
  endtask

  task automatic t_stuck();
    stuck = 11'h020;
    send(11'h0A0, 1'b1);
    wait_done();
    chk("R6", "diff count", 32'(diff_count), 2);
    chk("R7", "prog count", n_prog, 2);
    chk("R9", "verify error", 32'(error), 1);
    chk("R9", "store", 32'(store), 32'h77F);
    stuck = '0;
  endtask

  task automatic t_backpressure();
    int acc0;
    send(11'h003, 1'b1);
    acc0 = n_acc;
    repeat (10) @(negedge clk);
    chk("R1", "ready low busy", 32'(req_ready), 0);
    req_word = 11'h7FF; req_erase = 1'b0; req_valid = 1'b1;
    repeat (40) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    repeat (300) @(negedge clk);
    chk("R1", "no extra accept", n_acc, acc0);
    chk("R1", "prog count", n_prog, 2);
    chk("R3", "store", 32'(store), 32'h7FC);
    chk("R2", "min high phase", min_hi, HALF);
    chk("R2", "min low phase", min_lo, HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R10: actual=no finish expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_example();
    t_incr();
    t_same();
    t_refuse();
    t_full();
    t_stuck();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule